// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The block collects 64 level-sensitive interrupt request lines and presents them to a processor as two outputs. One is a normal interrupt request and the other is a fast interrupt request. Each line has an enable bit, a routing bit and a 4-bit priority. Lines routed to the normal output must also clear a programmable priority threshold before they can assert it. The highest-priority qualifying normal line is reported as a vector number. The processor can read this number to select a handler without scanning the pending lines.

Software talks to the block through a word-addressed synchronous register port. It can turn one line on or off by writing that line's number to a set register or a clear register. This avoids a read-modify-write of the enable words. The enable words can also be written whole. Register writes take effect on the clock edge that samples them. The outputs and the vector are registered, so they follow one edge later.

Top module: `vic_top`

## Requirements
- R1: A write of value n (n < 64) to the set-by-number register (word address 1) sets enable bit n on the next edge. Every other enable bit stays as it was.
- R2: A write of value n (n < 64) to the clear-by-number register (word address 2) clears enable bit n on the next edge. Every other enable bit stays as it was.
- R3: A write of 64 or more to either by-number register changes no enable bit.
- R4: Enable bits for lines 0–31 read and write at word address 3, and bits for lines 32–63 at word address 4. Bit i of each word maps to line i, or to line 32+i for the upper word.
- R5: Routing bits sit at word addresses 5 (lines 0–31) and 6 (lines 32–63). A routing bit of 0 selects the normal output and 1 selects the fast output. The fast output is the OR of all enabled, high lines routed to it, and the threshold does not gate it.
- R6: Priority words occupy word addresses 8–15. Line k's 4-bit priority is bits [4*(k%8)+3 : 4*(k%8)] of word 8 + k/8, so line 55 uses bits 31:28 of word 14.
- R7: The 5-bit threshold sits at word address 0, bits 4:0. A normal line qualifies when it is enabled, routed normal, high, and its priority is strictly greater than the threshold. A threshold of 15 or above lets every priority through. The normal output is the OR of the qualifying lines.
- R8: After reset the threshold reads 0x1F. All enable, routing and priority bits read 0, both outputs are low, and the vector reads 0xFFFF.
- R9: The vector (port and word address 7, bits 15:0) gives the number of the qualifying normal line with the highest priority. Among lines of equal priority the higher line number wins. The vector is 0xFFFF when no line qualifies.
- R10: Lines are level-sensitive and are not latched. When a line falls, its effect on the outputs disappears one edge later.
- R11: A source change is seen on the outputs after one clock edge. A register write is seen on the outputs after two edges: the first edge updates the register and the second updates the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level-sensitive request lines |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request (registered) |
| fiq_o | output | 1 | Fast interrupt request (registered) |
| vec_o | output | 16 | Winning normal line number, 0xFFFF if none (registered) |

## Verification
A corrupted enable, routing or priority bit shows up on the ports in two ways. It can be read back at once through its register word. It also changes the outputs and the vector one edge after the source pattern exposes it. The bench therefore reads back every word after by-number and direct writes. It then compares irq_o, fiq_o and vec_o against an arithmetic model over several hundred pseudo-random configurations of sources, routing, priorities and thresholds. Arbitration errors, such as the wrong tie-break or an off-by-one in the threshold compare, change the vector within a single cycle of the triggering pattern. Directed tie, threshold-edge and line-55 cases pin these errors down.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned MASK_W = 5;
  localparam int unsigned VEC_W  = 16;

  localparam logic [ADDR_W-1:0] A_MASK  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_EN0   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TYP0  = 4'd5;
  localparam logic [ADDR_W-1:0] A_VEC   = 4'd7;
  localparam logic [ADDR_W-1:0] A_PRIO0 = 4'd8;

  localparam logic [MASK_W-1:0] MASK_RST = '1;
  localparam logic [VEC_W-1:0]  VEC_NONE = '1;
endpackage

// File: rtl/vic_regs.sv
`timescale 1ns/1ps
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [VEC_W-1:0]                vec_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0]              typ_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [MASK_W-1:0]               mask_o
);
  localparam int unsigned IW         = $clog2(NUM_SRC);
  localparam int unsigned EN_WORDS   = NUM_SRC / DATA_W;
  localparam int unsigned PER_PWORD  = DATA_W / PRIO_W;
  localparam int unsigned PRIO_WORDS = NUM_SRC / PER_PWORD;

  logic [NUM_SRC-1:0]             en_q, en_d, typ_q, typ_d;
  logic [NUM_SRC-1:0][PRIO_W-1:0] pr_q, pr_d;
  logic [MASK_W-1:0]              mask_q, mask_d;
  logic                           idx_ok;
  logic [IW-1:0]                  idx;

  assign idx_ok = (wdata_i < DATA_W'(NUM_SRC));
  assign idx    = wdata_i[IW-1:0];

  always_comb begin
    en_d   = en_q;
    typ_d  = typ_q;
    pr_d   = pr_q;
    mask_d = mask_q;
    if (we_i) begin
      if (addr_i == A_MASK) mask_d = wdata_i[MASK_W-1:0];
      if (addr_i == A_ENSET && idx_ok) en_d[idx] = 1'b1;
      if (addr_i == A_ENCLR && idx_ok) en_d[idx] = 1'b0;
      for (int w = 0; w < EN_WORDS; w++) begin
        if (addr_i == ADDR_W'(A_EN0 + w))  en_d[w*DATA_W +: DATA_W]  = wdata_i;
        if (addr_i == ADDR_W'(A_TYP0 + w)) typ_d[w*DATA_W +: DATA_W] = wdata_i;
      end
      for (int r = 0; r < PRIO_WORDS; r++) begin
        if (addr_i == ADDR_W'(A_PRIO0 + r)) begin
          for (int s = 0; s < PER_PWORD; s++)
            pr_d[r*PER_PWORD+s] = wdata_i[s*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      pr_q   <= '0;
      mask_q <= MASK_RST;
    end else begin
      en_q   <= en_d;
      typ_q  <= typ_d;
      pr_q   <= pr_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASK) rdata_o[MASK_W-1:0] = mask_q;
    if (addr_i == A_VEC)  rdata_o[VEC_W-1:0]  = vec_i;
    for (int w = 0; w < EN_WORDS; w++) begin
      if (addr_i == ADDR_W'(A_EN0 + w))  rdata_o = en_q[w*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(A_TYP0 + w)) rdata_o = typ_q[w*DATA_W +: DATA_W];
    end
    for (int r = 0; r < PRIO_WORDS; r++) begin
      if (addr_i == ADDR_W'(A_PRIO0 + r)) begin
        for (int s = 0; s < PER_PWORD; s++)
          rdata_o[s*PRIO_W +: PRIO_W] = pr_q[r*PER_PWORD+s];
      end
    end
  end

  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign prio_o = pr_q;
  assign mask_o = mask_q;

  // R1
  a_r1_set_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENSET && idx_ok) |=> en_q[$past(idx)]);
  a_r1_set_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENSET && idx_ok) |=> ($countones(en_q ^ $past(en_q)) <= 1));
  // R2
  a_r2_clr_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENCLR && idx_ok) |=> !en_q[$past(idx)]);
  a_r2_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ENCLR && idx_ok) |=> ($countones(en_q ^ $past(en_q)) <= 1));
  // R3
  a_r3_oor_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_ENSET || addr_i == A_ENCLR) && !idx_ok) |=> $stable(en_q));
endmodule

// File: rtl/vic_qual.sv
`timescale 1ns/1ps
module vic_qual
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]             src_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0]             typ_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]              mask_i,
  output logic [NUM_SRC-1:0]             nq_o,
  output logic [NUM_SRC-1:0]             fq_o
);
  localparam logic [MASK_W-1:0] MASK_OFF_AT = MASK_W'((1 << PRIO_W) - 1);

  logic mask_off;
  assign mask_off = (mask_i >= MASK_OFF_AT);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic live;
    assign live    = en_i[k] & src_i[k];
    assign nq_o[k] = live & ~typ_i[k] & (mask_off | (MASK_W'(prio_i[k]) > mask_i));
    assign fq_o[k] = live & typ_i[k];
  end
endmodule

// File: rtl/vic_arb.sv
`timescale 1ns/1ps
module vic_arb
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IW     = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             valid_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [IW-1:0]                  idx_o
);
  localparam int unsigned NODES = 2 * NUM_SRC - 1;
  localparam int unsigned LEAF0 = NUM_SRC - 1;

  logic [NODES-1:0]             v;
  logic [NODES-1:0][PRIO_W-1:0] p;
  logic [NODES-1:0][IW-1:0]     ix;

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_leaf
    assign v[LEAF0+j]  = valid_i[j];
    assign p[LEAF0+j]  = prio_i[j];
    assign ix[LEAF0+j] = IW'(j);
  end

  // heap tree: right child covers higher line numbers, so >= gives ties to it
  for (genvar i = 0; i < NUM_SRC - 1; i++) begin : g_node
    logic take_r;
    assign take_r = v[2*i+2] && (!v[2*i+1] || p[2*i+2] >= p[2*i+1]);
    assign v[i]   = v[2*i+1] | v[2*i+2];
    assign p[i]   = take_r ? p[2*i+2]  : p[2*i+1];
    assign ix[i]  = take_r ? ix[2*i+2] : ix[2*i+1];
  end

  assign any_o = v[0];
  assign idx_o = ix[0];

  always_comb begin
    if (v[0]) begin
      a_r9_winner_live: assert (valid_i[ix[0]]);
    end
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int unsigned IW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]             en, typ, nq, fq;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [MASK_W-1:0]              mask;
  logic                           any;
  logic [IW-1:0]                  win;
  logic                           irq_q, fiq_q;
  logic [VEC_W-1:0]               vec_q;

  vic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .vec_i   (vec_q),
    .rdata_o (rdata_o),
    .en_o    (en),
    .typ_o   (typ),
    .prio_o  (prio),
    .mask_o  (mask)
  );

  vic_qual #(.NUM_SRC(NUM_SRC)) u_qual (
    .src_i  (src_i),
    .en_i   (en),
    .typ_i  (typ),
    .prio_i (prio),
    .mask_i (mask),
    .nq_o   (nq),
    .fq_o   (fq)
  );

  vic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .valid_i (nq),
    .prio_i  (prio),
    .any_o   (any),
    .idx_o   (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
      vec_q <= VEC_NONE;
    end else begin
      irq_q <= |nq;
      fiq_q <= |fq;
      vec_q <= any ? VEC_W'(win) : VEC_NONE;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
  assign vec_o = vec_q;

  // R9: vector and request line come from separate logic and must agree
  a_r9_vec_matches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_o != VEC_NONE));
  // R10
  a_r10_irq_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|src_i));
  // R5
  a_r5_fiq_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(|src_i));
  // R9
  a_r9_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == VEC_NONE) || (vec_o < VEC_W'(NUM_SRC)));
endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  localparam logic [3:0] W_MASK = 4'd0, W_SET = 4'd1, W_CLR = 4'd2, W_ENL = 4'd3,
                         W_ENH = 4'd4, W_TYL = 4'd5, W_TYH = 4'd6, W_VEC = 4'd7,
                         W_PR0 = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [15:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_en, m_typ, lf;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask;

  always #5 clk = ~clk;

  vic_top dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .vec_o(vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [63:0] nx(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic model(output logic ei, output logic ef, output logic [15:0] ev);
    int best;
    logic [3:0] bp;
    best = -1; bp = '0; ei = 1'b0; ef = 1'b0;
    for (int k = 0; k < 64; k++) begin
      if (m_en[k] && src[k]) begin
        if (m_typ[k]) ef = 1'b1;
        else if (m_mask >= 5'd15 || {1'b0, m_pr[k]} > m_mask) begin
          ei = 1'b1;
          if (best < 0 || m_pr[k] >= bp) begin best = k; bp = m_pr[k]; end
        end
      end
    end
    ev = (best < 0) ? 16'hFFFF : 16'(best);
  endtask

  task automatic check_outputs(input string req);
    logic ei, ef;
    logic [15:0] ev;
    logic [31:0] d;
    model(ei, ef, ev);
    chk({req, " irq"}, irq, ei);
    chk({req, " fiq"}, fiq, ef);
    chk({req, " vec"}, vec, ev);
    rd(W_VEC, d);
    chk({req, " vec reg"}, d, {16'h0, ev});
  endtask

  task automatic read_en(output logic [63:0] e);
    logic [31:0] lo, hi;
    rd(W_ENL, lo);
    rd(W_ENH, hi);
    e = {hi, lo};
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] e, exp_en, r;
    m_en = '0; m_typ = '0; m_mask = 5'h1F;
    for (int k = 0; k < 64; k++) m_pr[k] = '0;
    lf = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd(W_MASK, d); chk("R8 mask", d, 32'h1F);
    read_en(e);    chk("R8 enable", e, 64'h0);
    rd(W_TYL, d);  chk("R8 type lo", d, 0);
    rd(W_TYH, d);  chk("R8 type hi", d, 0);
    for (int r8 = 0; r8 < 8; r8++) begin rd(W_PR0 + 4'(r8), d); chk("R8 prio", d, 0); end
    chk("R8 irq", irq, 0); chk("R8 fiq", fiq, 0); chk("R8 vec", vec, 16'hFFFF);

    // R1 set-by-number sweep
    exp_en = '0;
    for (int k = 0; k < 64; k++) begin
      wr(W_SET, 32'(k));
      exp_en[k] = 1'b1;
      read_en(e); chk("R1 set", e, exp_en);
    end
    // R2 clear-by-number sweep on even lines
    for (int k = 0; k < 64; k += 2) begin
      wr(W_CLR, 32'(k));
      exp_en[k] = 1'b0;
      read_en(e); chk("R2 clear", e, exp_en);
    end
    // R3 out-of-range values
    wr(W_SET, 32'd64);         read_en(e); chk("R3 set 64", e, exp_en);
    wr(W_SET, 32'd100);        read_en(e); chk("R3 set 100", e, exp_en);
    wr(W_CLR, 32'd65);         read_en(e); chk("R3 clr 65", e, exp_en);
    wr(W_CLR, 32'hFFFF_FFFF);  read_en(e); chk("R3 clr max", e, exp_en);
    wr(W_SET, 32'h0000_0140);  read_en(e); chk("R3 set alias", e, exp_en);

    // R4 direct enable words
    wr(W_ENL, 32'hA5A5_0F0F); wr(W_ENH, 32'h1234_5678);
    read_en(e); chk("R4 enable words", e, 64'h1234_5678_A5A5_0F0F);
    wr(W_ENL, 32'h0); wr(W_ENH, 32'h0);
    read_en(e); chk("R4 enable clear", e, 64'h0);

    // R6 priority packing, line 55 at word 14 bits 31:28
    for (int w = 0; w < 8; w++) begin
      wr(W_PR0 + 4'(w), 32'h1357_9BDF ^ (32'(w) * 32'h1111_1111));
      rd(W_PR0 + 4'(w), d); chk("R6 prio readback", d, 32'h1357_9BDF ^ (32'(w) * 32'h1111_1111));
    end
    for (int k = 0; k < 64; k++) m_pr[k] = '0;
    for (int w = 0; w < 8; w++) wr(W_PR0 + 4'(w), 32'h0);
    wr(W_PR0 + 4'd6, 32'hF000_0000); m_pr[55] = 4'hF;
    wr(W_SET, 32'd55); m_en = '0; m_en[55] = 1'b1;
    wr(W_MASK, 32'd14); m_mask = 5'd14;
    src = '0; src[55] = 1'b1;
    @(negedge clk);
    chk("R6 line55 irq", irq, 1); chk("R6 line55 vec", vec, 16'd55);
    wr(W_PR0 + 4'd6, 32'hE000_0000); m_pr[55] = 4'hE;
    @(negedge clk);
    chk("R7 prio equal mask blocked", irq, 0); chk("R7 blocked vec", vec, 16'hFFFF);
    wr(W_MASK, 32'd13); m_mask = 5'd13;
    @(negedge clk);
    check_outputs("R7 prio above mask");
    wr(W_MASK, 32'd15); m_mask = 5'd15;
    wr(W_PR0 + 4'd6, 32'h0); m_pr[55] = 4'h0;
    @(negedge clk);
    check_outputs("R7 mask 15 open");

    // R11 register write timing: register edge then output edge
    wr(W_CLR, 32'd55); m_en[55] = 1'b0;
    chk("R11 write not yet visible", irq, 1);
    @(negedge clk);
    chk("R11 write visible", irq, 0);
    // R11 source timing and R10 level behaviour
    wr(W_SET, 32'd55); m_en[55] = 1'b1;
    @(negedge clk);
    src[55] = 1'b0;
    #2 chk("R11 source not yet visible", irq, 1);
    @(negedge clk);
    chk("R10 level drop", irq, 0); chk("R10 level drop vec", vec, 16'hFFFF);
    src[55] = 1'b1;
    @(negedge clk);
    chk("R10 level return", irq, 1);

    // R9 ties: equal priorities, higher number wins
    wr(W_ENL, 32'hFFFF_FFFF); wr(W_ENH, 32'hFFFF_FFFF); m_en = '1;
    wr(W_MASK, 32'h1F); m_mask = 5'h1F;
    src = '1;
    @(negedge clk);
    chk("R9 all tie", vec, 16'd63);
    src = '0; src[3] = 1'b1; src[40] = 1'b1;
    @(negedge clk);
    chk("R9 pair tie", vec, 16'd40);
    wr(W_PR0 + 4'd0, 32'h0000_2000); m_pr[3] = 4'h2;
    @(negedge clk);
    check_outputs("R9 higher prio lower number");
    // R5 routing of the winner to the fast line
    wr(W_TYL, 32'h0000_0008); m_typ = 64'h8;
    @(negedge clk);
    check_outputs("R5 route fast");
    wr(W_MASK, 32'd0); m_mask = 5'd0;
    @(negedge clk);
    check_outputs("R5 fast ignores mask");

    // R5 R7 R9 pseudo-random configurations
    for (int t = 0; t < 300; t++) begin
      lf = nx(lf); m_en = lf;
      wr(W_ENL, lf[31:0]); wr(W_ENH, lf[63:32]);
      lf = nx(lf); r = lf; lf = nx(lf); m_typ = r & lf;
      wr(W_TYL, m_typ[31:0]); wr(W_TYH, m_typ[63:32]);
      for (int w = 0; w < 8; w++) begin
        lf = nx(lf);
        wr(W_PR0 + 4'(w), lf[31:0]);
        for (int s = 0; s < 8; s++) m_pr[w*8+s] = lf[s*4 +: 4];
      end
      lf = nx(lf); m_mask = (t % 5 == 0) ? 5'h1F : lf[4:0];
      wr(W_MASK, 32'(m_mask));
      lf = nx(lf); r = lf;
      lf = nx(lf);
      src = (t % 3 == 0) ? (r & lf) : r;
      @(negedge clk);
      @(negedge clk);
      check_outputs("R5 R7 R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule